// File: doc/BRIEF.md
# Audio Sample FIFO with Level Flags

This block buffers audio samples between a host register port and a serial audio engine. A single direction input chooses the flow. In transmit mode the host pushes samples and the engine pops them. In receive mode the engine pushes samples and the host pops them. The storage is a circular buffer with a read pointer, a write pointer and an occupancy counter.

The block reports how full the buffer is as a coarse band code. It raises a service request when the fill level has crossed a programmable quarter threshold in the direction that needs the host. In transmit mode that means room to write. In receive mode it means data to read.

A single-cycle flush command empties the buffer. The flush is a pulse input that holds no state, so it always reads back as zero. A sticky error flag records when the engine has pushed into a full buffer or popped from an empty one, and a separate pulse clears the flag.

Top module: `audio_sample_fifo`

## Requirements
- R1: When `tx_mode_i`=1, the host write port pushes and the engine read port pops, and `host_rdata_o` is 0. When `tx_mode_i`=0, the engine write port pushes and the host read port pops, and `eng_rdata_o` is 0. Strobes on the inactive side have no effect.
- R2: Samples leave in the order they entered. A push is accepted only when the buffer is not full, and a refused push leaves contents and level unchanged. A pop is accepted only when the buffer is not empty.
- R3: `level_o` is computed with DEPTH=8, so each quarter band holds 2 entries. The code is 0 when empty, 1 for 1–2 entries, 2 for 3–4 entries, 3 for 5–6 entries, 4 for 7 entries and 5 when full (8 entries).
- R4: `thresh_i` code k (0..4) stands for k quarters of DEPTH. Codes 5 to 7 act as code 4.
- R5: In transmit mode, `req_o` is 1 exactly when the occupancy is at or below the threshold entry count.
- R6: In receive mode, `req_o` is 1 exactly when the occupancy is at or above the threshold entry count. Threshold code 0 means "any data present".
- R7: A cycle with `flush_i`=1 empties the buffer at that clock edge. Any push or pop in the same cycle is discarded.
- R8: `err_o` is set at the edge after either of two events: the engine writes while the buffer is full in receive mode (overrun), or the engine reads while the buffer is empty in transmit mode (underrun). Host-side misuse never sets it. The flag stays set until it is cleared.
- R9: `err_clr_i`=1 clears `err_o` at the next edge. If a new error occurs in the same cycle, the set wins.
- R10: An underrun pop returns zero data and leaves the level at 0.
- R11: A simultaneous push and pop on a buffer that is neither empty nor full leaves the occupancy unchanged.
- R12: After reset the buffer is empty (`level_o`=0) and `err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_mode_i | input | 1 | 1 = transmit, 0 = receive |
| thresh_i | input | 3 | Request threshold code |
| flush_i | input | 1 | Flush pulse |
| err_clr_i | input | 1 | Error flag clear pulse |
| host_wr_i | input | 1 | Host write strobe |
| host_wdata_i | input | WIDTH | Host write data |
| host_rd_i | input | 1 | Host read strobe |
| host_rdata_o | output | WIDTH | Head sample for the host (receive mode) |
| eng_wr_i | input | 1 | Engine write strobe |
| eng_wdata_i | input | WIDTH | Engine write data |
| eng_rd_i | input | 1 | Engine read strobe |
| eng_rdata_o | output | WIDTH | Head sample for the engine (transmit mode) |
| level_o | output | 3 | Fill band code |
| req_o | output | 1 | Service request |
| err_o | output | 1 | Sticky overrun/underrun flag |

## Verification
The assertions check a set of properties on every cycle. A full buffer stays full under refused pushes, and a flush leaves the buffer empty. An empty buffer returns zero data. Overrun, underrun and clear drive the error flag correctly. The request behaves correctly at the empty and full extremes, and a matched push and pop keep the band unchanged.

Other properties depend on history and only the bench's scenarios can show them. These are first-in-first-out data ordering, the exact band boundaries at every occupancy, the clamping of high threshold codes, and set-over-clear priority on the error flag. The bench covers them with a queue-based model under both directed and random traffic in each direction.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;
  typedef enum logic [2:0] {
    LVL_EMPTY = 3'd0,
    LVL_Q1    = 3'd1,
    LVL_Q2    = 3'd2,
    LVL_Q3    = 3'd3,
    LVL_Q4    = 3'd4,
    LVL_FULL  = 3'd5
  } fill_band_e;

  localparam logic [2:0] THR_MAX = 3'd4;
endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic [CW-1:0]    count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wptr_q, rptr_q;
  logic [CW-1:0]    cnt_q;
  logic             push_ok, pop_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;
  assign head_o  = empty_o ? '0 : mem_q[rptr_q];
  assign count_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (flush_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= (wptr_q == AW'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (pop_ok)  rptr_q <= (rptr_q == AW'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // data array carries no reset
  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wptr_q] <= push_data_i;
  end
endmodule

// File: rtl/afifo_level.sv
module afifo_level import audio_fifo_pkg::*; #(
  parameter int DEPTH = 8,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int QTR = DEPTH / 4
) (
  input  logic [CW-1:0] count_i,
  input  logic [2:0]    thresh_i,
  input  logic          tx_mode_i,
  output logic [2:0]    level_o,
  output logic          req_o
);
  logic [2:0]    thr_eff;
  logic [CW-1:0] thr_cnt;
  fill_band_e    band;

  always_comb begin
    if (count_i == '0)                    band = LVL_EMPTY;
    else if (count_i == CW'(DEPTH))       band = LVL_FULL;
    else if (count_i <= CW'(QTR))         band = LVL_Q1;
    else if (count_i <= CW'(2 * QTR))     band = LVL_Q2;
    else if (count_i <= CW'(3 * QTR))     band = LVL_Q3;
    else                                  band = LVL_Q4;
  end

  assign level_o = band;
  assign thr_eff = (thresh_i > THR_MAX) ? THR_MAX : thresh_i;
  assign thr_cnt = CW'(thr_eff) * CW'(QTR);

  always_comb begin
    if (tx_mode_i)             req_o = (count_i <= thr_cnt);
    else if (thr_eff == '0)    req_o = (count_i != '0);
    else                       req_o = (count_i >= thr_cnt);
  end
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo import audio_fifo_pkg::*; #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_mode_i,
  input  logic [2:0]       thresh_i,
  input  logic             flush_i,
  input  logic             err_clr_i,
  input  logic             host_wr_i,
  input  logic [WIDTH-1:0] host_wdata_i,
  input  logic             host_rd_i,
  output logic [WIDTH-1:0] host_rdata_o,
  input  logic             eng_wr_i,
  input  logic [WIDTH-1:0] eng_wdata_i,
  input  logic             eng_rd_i,
  output logic [WIDTH-1:0] eng_rdata_o,
  output logic [2:0]       level_o,
  output logic             req_o,
  output logic             err_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic             push, pop, full, empty, err_set;
  logic [WIDTH-1:0] push_data, head;
  logic [CW-1:0]    count;
  logic             err_q;

  assign push      = tx_mode_i ? host_wr_i    : eng_wr_i;
  assign push_data = tx_mode_i ? host_wdata_i : eng_wdata_i;
  assign pop       = tx_mode_i ? eng_rd_i     : host_rd_i;

  afifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .push_i      (push),
    .push_data_i (push_data),
    .pop_i       (pop),
    .head_o      (head),
    .count_o     (count),
    .full_o      (full),
    .empty_o     (empty)
  );

  afifo_level #(.DEPTH(DEPTH)) u_level (
    .count_i   (count),
    .thresh_i  (thresh_i),
    .tx_mode_i (tx_mode_i),
    .level_o   (level_o),
    .req_o     (req_o)
  );

  assign host_rdata_o = tx_mode_i ? '0 : head;
  assign eng_rdata_o  = tx_mode_i ? head : '0;

  // engine-side faults only
  assign err_set = (!tx_mode_i && eng_wr_i && full) || (tx_mode_i && eng_rd_i && empty);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        err_q <= 1'b0;
    else if (err_set)   err_q <= 1'b1;
    else if (err_clr_i) err_q <= 1'b0;
  end
  assign err_o = err_q;
endmodule

// File: rtl/afifo_checker.sv
module afifo_checker #(
  parameter int WIDTH = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_mode_i,
  input logic             flush_i,
  input logic             err_clr_i,
  input logic             host_wr_i,
  input logic             host_rd_i,
  input logic             eng_wr_i,
  input logic             eng_rd_i,
  input logic [WIDTH-1:0] host_rdata_o,
  input logic [WIDTH-1:0] eng_rdata_o,
  input logic [2:0]       level_o,
  input logic             req_o,
  input logic             err_o
);
  logic push_s, pop_s, fault_s;
  assign push_s  = tx_mode_i ? host_wr_i : eng_wr_i;
  assign pop_s   = tx_mode_i ? eng_rd_i : host_rd_i;
  assign fault_s = (!tx_mode_i && eng_wr_i && level_o == 3'd5) ||
                   (tx_mode_i && eng_rd_i && level_o == 3'd0);

  assert_level_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= 3'd5);
  assert_full_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == 3'd5 && !pop_s && !flush_i) |=> level_o == 3'd5);
  assert_flush_empties_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> level_o == 3'd0);
  assert_empty_zero_data_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o == 3'd0 |-> (host_rdata_o == '0 && eng_rdata_o == '0));
  assert_fault_sets_err_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_s |=> err_o);
  assert_clear_err_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_clr_i && !fault_s) |=> !err_o);
  assert_tx_empty_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_mode_i && level_o == 3'd0) |-> req_o);
  assert_rx_empty_noreq_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_mode_i && level_o == 3'd0) |-> !req_o);
  assert_rx_full_req_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tx_mode_i && level_o == 3'd5) |-> req_o);
  assert_push_pop_level_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_s && pop_s && !flush_i && level_o != 3'd0 && level_o != 3'd5) |=> $stable(level_o));
  assert_idle_level_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!push_s && !pop_s && !flush_i) |=> $stable(level_o));
endmodule

bind audio_sample_fifo afifo_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_mode_i    (tx_mode_i),
  .flush_i      (flush_i),
  .err_clr_i    (err_clr_i),
  .host_wr_i    (host_wr_i),
  .host_rd_i    (host_rd_i),
  .eng_wr_i     (eng_wr_i),
  .eng_rd_i     (eng_rd_i),
  .host_rdata_o (host_rdata_o),
  .eng_rdata_o  (eng_rdata_o),
  .level_o      (level_o),
  .req_o        (req_o),
  .err_o        (err_o)
);

// File: tb/sim_audio_sample_fifo.sv
module sim_audio_sample_fifo;
  localparam int W = 32;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         tx_mode_i = 1'b1;
  logic [2:0]   thresh_i = '0;
  logic         flush_i = 1'b0, err_clr_i = 1'b0;
  logic         host_wr_i = 1'b0, host_rd_i = 1'b0, eng_wr_i = 1'b0, eng_rd_i = 1'b0;
  logic [W-1:0] host_wdata_i = '0, eng_wdata_i = '0;
  logic [W-1:0] host_rdata_o, eng_rdata_o;
  logic [2:0]   level_o;
  logic         req_o, err_o;

  int total = 0;
  int bad = 0;

  logic [W-1:0] mq[$];
  bit           m_err = 0;

  always #5 clk_i = ~clk_i;

  audio_sample_fifo #(.DEPTH(8), .WIDTH(W)) u0 (.*);

  task automatic chk(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [2:0] exp_level();
    int n = mq.size();
    if (n == 0) return 3'd0;
    if (n == 8) return 3'd5;
    if (n <= 2) return 3'd1;
    if (n <= 4) return 3'd2;
    if (n <= 6) return 3'd3;
    return 3'd4;
  endfunction

  function automatic logic exp_req();
    int k = (thresh_i > 3'd4) ? 4 : int'(thresh_i);
    int n = mq.size();
    if (tx_mode_i) return n <= 2 * k;
    if (k == 0) return n > 0;
    return n >= 2 * k;
  endfunction

  task automatic idle();
    flush_i = 0; err_clr_i = 0; host_wr_i = 0; host_rd_i = 0; eng_wr_i = 0; eng_rd_i = 0;
  endtask

  // compare before the edge, then advance the model at the edge
  task automatic cyc();
    logic [W-1:0] head;
    bit push, pop, fault;
    logic [W-1:0] pd;
    #1;
    head = (mq.size() > 0) ? mq[0] : '0;
    chk(level_o == exp_level(), "R3 level", W'(level_o), W'(exp_level()));
    chk(req_o == exp_req(), tx_mode_i ? "R5 req" : "R6 req", W'(req_o), W'(exp_req()));
    chk(host_rdata_o == (tx_mode_i ? '0 : head), "R1 host_rdata", host_rdata_o, tx_mode_i ? '0 : head);
    chk(eng_rdata_o == (tx_mode_i ? head : '0), "R1 eng_rdata", eng_rdata_o, tx_mode_i ? head : '0);
    chk(err_o == m_err, "R8 err", W'(err_o), W'(m_err));
    @(posedge clk_i);
    push  = tx_mode_i ? host_wr_i : eng_wr_i;
    pd    = tx_mode_i ? host_wdata_i : eng_wdata_i;
    pop   = tx_mode_i ? eng_rd_i : host_rd_i;
    fault = (!tx_mode_i && eng_wr_i && mq.size() == 8) || (tx_mode_i && eng_rd_i && mq.size() == 0);
    if (flush_i) mq.delete();
    else begin
      bit full_pre = (mq.size() == 8);
      if (pop && mq.size() > 0) void'(mq.pop_front());
      if (push && !full_pre) mq.push_back(pd);
    end
    if (fault) m_err = 1;
    else if (err_clr_i) m_err = 0;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    chk(level_o == 3'd0, "R12 reset level", W'(level_o), 0);
    chk(err_o == 1'b0, "R12 reset err", W'(err_o), 0);
    @(negedge clk_i);
    rst_ni = 1;

    // transmit fill past full
    tx_mode_i = 1; thresh_i = 3'd2;
    for (int i = 0; i < 10; i++) begin
      idle(); host_wr_i = 1; host_wdata_i = 32'hA000_0000 + i; cyc();
    end
    idle(); eng_wr_i = 1; cyc(); // inactive side in tx
    #1 chk(level_o == 3'd5, "R2 refused push keeps full", W'(level_o), 5);
    chk(err_o == 0, "R8 host overflow no error", W'(err_o), 0);
    thresh_i = 3'd6; #1 chk(req_o == 1'b1, "R4 clamp to full", W'(req_o), 1);
    thresh_i = 3'd3; #1 chk(req_o == 1'b0, "R5 full above 3/4", W'(req_o), 0);
    cyc();
    // drain then underrun
    for (int i = 0; i < 8; i++) begin
      idle(); eng_rd_i = 1;
      #1 chk(eng_rdata_o == 32'hA000_0000 + i, "R2 order", eng_rdata_o, 32'hA000_0000 + i);
      cyc();
    end
    idle(); eng_rd_i = 1;
    #1 chk(eng_rdata_o == '0, "R10 underrun data", eng_rdata_o, 0);
    cyc();
    idle();
    #1 chk(err_o == 1 && level_o == 0, "R10 underrun err set level 0", {err_o, level_o}, 4'b1000);
    err_clr_i = 1; cyc(); idle();
    #1 chk(err_o == 0, "R9 clear", W'(err_o), 0);
    eng_rd_i = 1; err_clr_i = 1; cyc(); idle();
    #1 chk(err_o == 1, "R9 set wins", W'(err_o), 1);
    err_clr_i = 1; cyc(); idle();

    // simultaneous push/pop
    for (int i = 0; i < 3; i++) begin host_wr_i = 1; host_wdata_i = 32'hB0 + i; cyc(); end
    for (int i = 0; i < 4; i++) begin
      idle(); host_wr_i = 1; eng_rd_i = 1; host_wdata_i = 32'hC0 + i; cyc();
    end
    idle();
    #1 chk(level_o == 3'd2, "R11 level kept", W'(level_o), 2);
    flush_i = 1; host_wr_i = 1; cyc(); idle();
    #1 chk(level_o == 3'd0, "R7 flush empties", W'(level_o), 0);

    // receive mode
    tx_mode_i = 0; thresh_i = 3'd0;
    host_wr_i = 1; cyc(); idle();
    #1 chk(level_o == 3'd0, "R1 host write ignored in rx", W'(level_o), 0);
    chk(req_o == 1'b0, "R6 thr0 no data", W'(req_o), 0);
    for (int i = 0; i < 9; i++) begin
      idle(); eng_wr_i = 1; eng_wdata_i = 32'hD000 + i; cyc();
    end
    idle();
    #1 chk(err_o == 1, "R8 overrun", W'(err_o), 1);
    chk(host_rdata_o == 32'hD000, "R1 rx head", host_rdata_o, 32'hD000);
    err_clr_i = 1; cyc(); idle();
    thresh_i = 3'd4; host_rd_i = 1; cyc(); idle();
    #1 chk(req_o == 1'b0, "R6 below full threshold", W'(req_o), 0);

    // random traffic in both modes
    for (int m = 0; m < 2; m++) begin
      tx_mode_i = (m == 0);
      for (int i = 0; i < 3000; i++) begin
        if (i % 97 == 0) thresh_i = 3'($urandom_range(0, 7));
        flush_i      = ($urandom_range(0, 59) == 0);
        err_clr_i    = ($urandom_range(0, 29) == 0);
        host_wr_i    = $urandom_range(0, 1);
        host_rd_i    = $urandom_range(0, 1);
        eng_wr_i     = $urandom_range(0, 1);
        eng_rd_i     = $urandom_range(0, 1);
        host_wdata_i = $urandom;
        eng_wdata_i  = $urandom;
        cyc();
      end
      idle();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule